// File: doc/BRIEF.md
# PCM Serial Frame Shifter

This block is the bit-level engine of a short-frame PCM audio port that runs as clock and sync master. A separate clock generator supplies a one-cycle strobe for each falling bit-clock edge, a one-cycle strobe for each rising bit-clock edge, and a frame-sync flag that is raised together with the falling-edge strobe that opens a frame. In every frame the engine sends one stereo pair of 16-bit samples, MSB first, on the serial output and collects one pair from the serial input. The output changes on falling edges and the input is sampled on rising edges. Bit-clock and sync polarity are always normal.

Transmit words come from a first-word-fall-through FIFO through a pop strobe. Received words go to a FIFO through a push strobe. Both are 32 bits wide, with the left sample in bits 31:16 and the right sample in bits 15:0, so the left channel is on the wire first. Each direction has its own select for the MSB position. When the select is set, the MSB follows the sync slot by one bit-clock. When it is clear, the MSB shares the sync slot. A direction shifts only while the port enable and that direction's enable are both high.

Each direction runs a three-state machine. SH_WAIT idles with the line low. SH_LEAD is the sync slot in delayed-MSB mode. SH_SHIFT moves the 32 data bits. The transitions are:
- start: any sync strobe while the direction is active goes to SH_LEAD (delayed mode) or to SH_SHIFT (aligned mode), abandoning any frame in progress.
- lead_done: a falling strobe in SH_LEAD goes to SH_SHIFT.
- frame_done: after the last bit, transmit returns to SH_WAIT on the next falling strobe, and receive returns to SH_WAIT on the rising strobe that takes bit 0.
- off: the direction becoming inactive forces SH_WAIT from any state.

Top module: `pcm_frame_shifter`

## Requirements
- R1: After reset, ser_out, tx_pop, tx_starve and rx_push are all 0.
- R2: When transmit is active and tx_empty is 0, a sync strobe raises tx_pop for exactly that one cycle, so the FIFO gets exactly one pop per frame.
- R3: With tx_msb_late=0 the sync slot (slot 0) carries word bit 31, and slot s (0..31) carries bit 31-s.
- R4: With tx_msb_late=1 the sync slot carries 0, and slot s (1..32) carries bit 32-s.
- R5: Every slot after the last data bit, up to the next sync, carries 0 on ser_out.
- R6: When transmit is active and tx_empty is 1 at a sync strobe, tx_starve pulses for that cycle, tx_pop stays 0, and all 32 data slots carry 0.
- R7: With rx_msb_late=0 the bit sampled in slot s (0..31) becomes received bit 31-s, and one rx_push with the full word follows the rising strobe of slot 31.
- R8: With rx_msb_late=1 the bit sampled in slot s (1..32) becomes received bit 32-s, and the push follows the rising strobe of slot 32.
- R9: ser_in values in the sync slot of delayed mode and in the slots after the last data bit do not affect the received word.
- R10: A direction is active only while port_en and its own enable are both 1. An inactive transmitter keeps ser_out at 0 and never pops or starves. An inactive receiver never pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Global port enable |
| tx_dir_en | input | 1 | Transmit direction enable |
| rx_dir_en | input | 1 | Receive direction enable |
| tx_msb_late | input | 1 | 1: transmit MSB one bit-clock after sync; 0: MSB in the sync slot |
| rx_msb_late | input | 1 | 1: receive MSB one bit-clock after sync; 0: MSB in the sync slot |
| bit_fall | input | 1 | Strobe marking a falling bit-clock edge |
| bit_rise | input | 1 | Strobe marking a rising bit-clock edge |
| frame_sync | input | 1 | Frame sync, valid together with bit_fall |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output |
| tx_pop | output | 1 | Pop strobe to the transmit FIFO |
| tx_word | input | 32 | Head word of the transmit FIFO {left, right} |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_starve | output | 1 | Pulse: transmit FIFO was empty at frame start |
| rx_push | output | 1 | Push strobe to the receive FIFO |
| rx_word | output | 32 | Received word {left, right}, valid with rx_push |

## Verification
ser_out is registered on the clock edge that carries bit_fall, and the bench reads it two cycles later, at the negative clock edge just before the same slot's rising strobe. tx_pop and tx_starve are combinational in the cycle of the sync strobe, so they are sampled 1 ns after the bench drives the strobe. rx_push rises one cycle after the rising strobe of the last data slot, and every cycle is sampled 1 ns after the negative clock edge so that each push is counted exactly once. A sweep covers every pair of transmit and receive MSB modes with several data patterns. During it, receive gap slots and the delayed-mode sync slot are driven to 1, so any sampling outside the data slots shows up as a corrupted word.

// File: rtl/pcm_shift_pkg.sv
package pcm_shift_pkg;

    typedef enum logic [1:0] {
        SH_WAIT  = 2'd0,
        SH_LEAD  = 2'd1,
        SH_SHIFT = 2'd2
    } sh_state_e;

    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;
    localparam int NUM_DIR = 2;

endpackage

// File: rtl/pcm_dir_gate.sv
module pcm_dir_gate #(
    parameter int NUM_DIR = 2
) (
    input  logic               port_en,
    input  logic [NUM_DIR-1:0] dir_en,
    output logic [NUM_DIR-1:0] dir_act
);

    // A direction runs only when the port and its own enable are both set
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        assign dir_act[d] = port_en & dir_en[d];
    end

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
    import pcm_shift_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act,
    input  logic               msb_late,
    input  logic               bit_fall,
    input  logic               frame_sync,
    input  logic [FRAME_W-1:0] word_in,
    input  logic               fifo_empty,
    output logic               pop,
    output logic               starve,
    output logic               ser_out
);

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    sh_state_e          state_q, state_d;
    logic [FRAME_W-1:0] sh_q, sh_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               out_q, out_d;
    logic               start;
    logic [FRAME_W-1:0] load_word;

    assign start     = bit_fall & frame_sync & act;
    assign load_word = fifo_empty ? '0 : word_in;

    // Next-state and datapath
    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        if (!act) begin
            state_d = SH_WAIT;
            sh_d    = '0;
            cnt_d   = '0;
            out_d   = 1'b0;
        end else if (start) begin
            if (msb_late) begin
                state_d = SH_LEAD;
                sh_d    = load_word;
                out_d   = 1'b0;
            end else begin
                state_d = SH_SHIFT;
                out_d   = load_word[FRAME_W-1];
                sh_d    = {load_word[FRAME_W-2:0], 1'b0};
                cnt_d   = LAST;
            end
        end else if (bit_fall) begin
            unique case (state_q)
                SH_WAIT: begin
                    out_d = 1'b0;
                end
                SH_LEAD: begin
                    state_d = SH_SHIFT;
                    out_d   = sh_q[FRAME_W-1];
                    sh_d    = {sh_q[FRAME_W-2:0], 1'b0};
                    cnt_d   = LAST;
                end
                SH_SHIFT: begin
                    if (cnt_q == '0) begin
                        state_d = SH_WAIT;
                        out_d   = 1'b0;
                    end else begin
                        out_d = sh_q[FRAME_W-1];
                        sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = SH_WAIT;
                    out_d   = 1'b0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_WAIT;
            sh_q    <= '0;
            cnt_q   <= '0;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
            out_q   <= out_d;
        end
    end

    // Outputs
    always_comb begin
        pop     = start & ~fifo_empty;
        starve  = start & fifo_empty;
        ser_out = out_q;
    end

    a_r5_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_WAIT) |-> (out_q == 1'b0));

    a_r10_tx_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (out_q == 1'b0 && state_q == SH_WAIT));

    a_r6_starve_sends_zero: assert property (@(posedge clk) disable iff (!rst_n)
        starve |=> (out_q == 1'b0));

    a_r4_lead_slot_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_LEAD) |-> (out_q == 1'b0));

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
    import pcm_shift_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act,
    input  logic               msb_late,
    input  logic               bit_fall,
    input  logic               bit_rise,
    input  logic               frame_sync,
    input  logic               ser_in,
    output logic               push,
    output logic [FRAME_W-1:0] word_out
);

    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    sh_state_e          state_q, state_d;
    logic [FRAME_W-1:0] sh_q, sh_d;
    logic [FRAME_W-1:0] word_q, word_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               push_q, push_d;
    logic               start;

    assign start = bit_fall & frame_sync & act;

    // Next-state and datapath
    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        word_d  = word_q;
        cnt_d   = cnt_q;
        push_d  = 1'b0;
        if (!act) begin
            state_d = SH_WAIT;
            cnt_d   = '0;
        end else if (start) begin
            state_d = msb_late ? SH_LEAD : SH_SHIFT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                SH_WAIT: begin
                    cnt_d = '0;
                end
                SH_LEAD: begin
                    if (bit_fall) begin
                        state_d = SH_SHIFT;
                        cnt_d   = '0;
                    end
                end
                SH_SHIFT: begin
                    if (bit_rise) begin
                        sh_d  = {sh_q[FRAME_W-2:0], ser_in};
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            push_d  = 1'b1;
                            word_d  = {sh_q[FRAME_W-2:0], ser_in};
                            state_d = SH_WAIT;
                        end
                    end
                end
                default: begin
                    state_d = SH_WAIT;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_WAIT;
            sh_q    <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
            push_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            word_q  <= word_d;
            cnt_q   <= cnt_d;
            push_q  <= push_d;
        end
    end

    // Outputs
    always_comb begin
        push     = push_q;
        word_out = word_q;
    end

    a_r7_push_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        push_q |=> !push_q);

    a_r9_word_held_between_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        !push_q |-> $stable(word_q));

    a_r10_rx_off_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> !push_q);

    a_r8_push_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        push_q |-> (state_q == SH_WAIT));

endmodule

// File: rtl/pcm_frame_shifter.sv
module pcm_frame_shifter
    import pcm_shift_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CHANNELS = 2,
    localparam int FRAME_W = SAMPLE_W * CHANNELS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               tx_dir_en,
    input  logic               rx_dir_en,
    input  logic               tx_msb_late,
    input  logic               rx_msb_late,
    input  logic               bit_fall,
    input  logic               bit_rise,
    input  logic               frame_sync,
    input  logic               ser_in,
    output logic               ser_out,
    output logic               tx_pop,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               tx_empty,
    output logic               tx_starve,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_word
);

    logic [NUM_DIR-1:0] dir_en;
    logic [NUM_DIR-1:0] dir_act;

    assign dir_en[DIR_TX] = tx_dir_en;
    assign dir_en[DIR_RX] = rx_dir_en;

    pcm_dir_gate #(
        .NUM_DIR (NUM_DIR)
    ) u_gate (
        .port_en (port_en),
        .dir_en  (dir_en),
        .dir_act (dir_act)
    );

    pcm_tx_shifter #(
        .FRAME_W (FRAME_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (dir_act[DIR_TX]),
        .msb_late   (tx_msb_late),
        .bit_fall   (bit_fall),
        .frame_sync (frame_sync),
        .word_in    (tx_word),
        .fifo_empty (tx_empty),
        .pop        (tx_pop),
        .starve     (tx_starve),
        .ser_out    (ser_out)
    );

    pcm_rx_shifter #(
        .FRAME_W (FRAME_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (dir_act[DIR_RX]),
        .msb_late   (rx_msb_late),
        .bit_fall   (bit_fall),
        .bit_rise   (bit_rise),
        .frame_sync (frame_sync),
        .ser_in     (ser_in),
        .push       (rx_push),
        .word_out   (rx_word)
    );

    a_r2_pop_not_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    a_r10_tx_inactive_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_en && tx_dir_en) |-> !(tx_pop || tx_starve));

endmodule

// File: tb/test_pcm_frame_shifter.sv
`timescale 1ns/1ps
module test_pcm_frame_shifter;

    localparam int FW    = 32;
    localparam int SLOTS = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          port_en = 1'b0;
    logic          tx_dir_en = 1'b0;
    logic          rx_dir_en = 1'b0;
    logic          tx_msb_late = 1'b0;
    logic          rx_msb_late = 1'b0;
    logic          bit_fall = 1'b0;
    logic          bit_rise = 1'b0;
    logic          frame_sync = 1'b0;
    logic          ser_in = 1'b0;
    logic          ser_out;
    logic          tx_pop;
    logic [FW-1:0] tx_word = '0;
    logic          tx_empty = 1'b0;
    logic          tx_starve;
    logic          rx_push;
    logic [FW-1:0] rx_word;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    pcm_frame_shifter i_pcm_frame_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_en     (port_en),
        .tx_dir_en   (tx_dir_en),
        .rx_dir_en   (rx_dir_en),
        .tx_msb_late (tx_msb_late),
        .rx_msb_late (rx_msb_late),
        .bit_fall    (bit_fall),
        .bit_rise    (bit_rise),
        .frame_sync  (frame_sync),
        .ser_in      (ser_in),
        .ser_out     (ser_out),
        .tx_pop      (tx_pop),
        .tx_word     (tx_word),
        .tx_empty    (tx_empty),
        .tx_starve   (tx_starve),
        .rx_push     (rx_push),
        .rx_word     (rx_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_tx_bit(input logic [31:0] w, input bit late, input int s);
        if (!late) return (s < FW) ? w[FW-1-s] : 1'b0;
        return (s >= 1 && s <= FW) ? w[FW-s] : 1'b0;
    endfunction

    function automatic bit is_data_slot(input bit late, input int s);
        return late ? (s >= 1 && s <= FW) : (s < FW);
    endfunction

    // Gap and delayed-mode sync slots carry 1 so stray sampling corrupts the word (R9)
    function automatic logic rx_line_bit(input logic [31:0] w, input bit late, input int s);
        if (!late) return (s < FW) ? w[FW-1-s] : 1'b1;
        return (s >= 1 && s <= FW) ? w[FW-s] : 1'b1;
    endfunction

    task automatic run_frame(input logic [31:0] txw, input bit empty, input logic [31:0] rxw,
                             input bit tl, input bit rl, input bit pen, input bit ten, input bit ren);
        int pops = 0;
        int starves = 0;
        int pushes = 0;
        int data_bad = 0;
        int gap_bad = 0;
        logic [31:0] got = '0;
        logic bad_act = 1'b0;
        logic bad_exp = 1'b0;
        bit tx_on;
        string mode_req;
        tx_on = pen && ten;
        mode_req = tl ? "R4" : "R3";
        for (int s = 0; s < SLOTS; s++) begin
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                if (s == 0 && p == 0) begin
                    port_en = pen; tx_dir_en = ten; rx_dir_en = ren;
                    tx_msb_late = tl; rx_msb_late = rl;
                    tx_word = txw; tx_empty = empty;
                end
                bit_fall   = (p == 0);
                bit_rise   = (p == 2);
                frame_sync = (p == 0 && s == 0);
                if (p == 0) ser_in = rx_line_bit(rxw, rl, s);
                #1;
                if (tx_pop) pops++;
                if (tx_starve) starves++;
                if (rx_push) begin pushes++; got = rx_word; end
                if (p == 2) begin
                    logic e;
                    e = (tx_on && !empty) ? exp_tx_bit(txw, tl, s) : 1'b0;
                    if (ser_out !== e) begin
                        if (tx_on && is_data_slot(tl, s)) data_bad++;
                        else gap_bad++;
                        bad_act = ser_out; bad_exp = e;
                    end
                end
            end
        end
        if (!tx_on)
            check(data_bad == 0 && gap_bad == 0, "R10 ser_out low when off", 32'(bad_act), 32'(bad_exp));
        else if (empty)
            check(data_bad == 0 && gap_bad == 0, "R6 zeros on starve", 32'(bad_act), 32'(bad_exp));
        else begin
            check(data_bad == 0, mode_req, 32'(data_bad), 32'd0);
            check(gap_bad == 0, "R5 gap slots low", 32'(gap_bad), 32'd0);
        end
        if (tx_on && !empty) check(pops == 1, "R2 one pop", 32'(pops), 32'd1);
        else check(pops == 0, "R10 R6 no pop", 32'(pops), 32'd0);
        check(starves == ((tx_on && empty) ? 1 : 0), "R6 starve pulse", 32'(starves), 32'((tx_on && empty) ? 1 : 0));
        if (pen && ren) begin
            check(pushes == 1, rl ? "R8 push count" : "R7 push count", 32'(pushes), 32'd1);
            check(got == rxw, rl ? "R8 R9 rx word" : "R7 R9 rx word", got, rxw);
        end else begin
            check(pushes == 0, "R10 no push when off", 32'(pushes), 32'd0);
        end
    endtask

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'hA5A5_3C3C;
        pats[1] = 32'h8000_0001;
        pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'h0000_0000;
        pats[4] = 32'h1234_5678;
        pats[5] = 32'h7FFE_8001;
        repeat (3) @(negedge clk);
        #1;
        check(ser_out == 1'b0 && tx_pop == 1'b0 && tx_starve == 1'b0 && rx_push == 1'b0,
              "R1 reset state", {28'd0, ser_out, tx_pop, tx_starve, rx_push}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int tl = 0; tl < 2; tl++) begin
            for (int rl = 0; rl < 2; rl++) begin
                for (int i = 0; i < 6; i++) begin
                    run_frame(pats[i], 1'b0, ~pats[(i + 1) % 6] ^ 32'(i * 32'h0101_0101),
                              tl[0], rl[0], 1'b1, 1'b1, 1'b1);
                end
            end
        end
        // R6: empty transmit FIFO in both MSB modes
        run_frame(32'hDEAD_BEEF, 1'b1, 32'h0F0F_F0F0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        run_frame(32'hDEAD_BEEF, 1'b1, 32'hF0F0_0F0F, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        // R10: gating combinations
        run_frame(32'hCAFE_F00D, 1'b0, 32'h1357_9BDF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        run_frame(32'hCAFE_F00D, 1'b0, 32'h2468_ACE0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        run_frame(32'hCAFE_F00D, 1'b0, 32'h2468_ACE0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        // Recovery after gating
        run_frame(32'h5A5A_C3C3, 1'b0, 32'h9669_6996, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        bit_fall = 1'b0; bit_rise = 1'b0; frame_sync = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule